// File: doc/BRIEF.md
# Byte-Laned SRAM with Per-Byte ECC

A single-port clocked memory with a 16-bit data path, split into two 8-bit byte lanes. Its controls mimic a static RAM: active-low select, output enable and write enable, plus one active-low enable per lane. A write is taken on the rising clock edge. A read returns data one cycle after the request. The bus has no tri-state: each lane has its own output-valid flag.

Every stored byte carries four check bits of its own, so a lane holds a 12-bit codeword. A write to one lane encodes and stores only that lane's codeword. A read decodes the codeword, repairs any single flipped bit and flags patterns it cannot repair. A test-only injection port flips one chosen stored bit, which lets the correction path be exercised. The depth is a parameter. The default is small, and the full 131,072 words is also allowed.

Top module: `blsram_top`

## Requirements
- R1: With `cs_n`=0 and `we_n`=0, every lane whose `lane_n` bit is 0 stores its byte of `wdata` at `addr` on the clock edge, whatever `oe_n` is. Lane 0 is `wdata[7:0]` and lane 1 is `wdata[15:8]`. A lane whose `lane_n` bit is 1 keeps its stored byte.
- R2: With `cs_n`=0, `we_n`=1 and `oe_n`=0, each lane whose `lane_n` bit is 0 returns its stored byte on its slice of `rdata` in the next cycle, with its `rvld` bit set.
- R3: With `cs_n`=1, no lane is written and `rvld` is 00 in the next cycle.
- R4: With `cs_n`=0, `we_n`=1 and `oe_n`=1, nothing is written and `rvld` is 00 in the next cycle.
- R5: With `cs_n`=0 and `lane_n`=11, nothing is written and `rvld` is 00 in the next cycle.
- R6: The cycle after a write has `rvld` 00.
- R7: A lane whose `rvld` bit is 0 shows a zero byte on `rdata`, and its `fix` and `bad` bits are 0.
- R8: A codeword has 12 positions, numbered 1 to 12. The check bits sit at positions 1, 2, 4 and 8. Data bits 0 to 7 sit at positions 3, 5, 6, 7, 9, 10, 11 and 12. The syndrome is the XOR of the position numbers of all set bits. When exactly one stored bit of a lane differs from its written codeword, the read returns the written byte with that lane's `fix` bit set and `bad` clear.
- R9: A syndrome from 13 to 15 sets that lane's `bad` bit and clears `fix`. The byte is then returned as stored, with no correction. An example is two flips at positions whose XOR is above 12.
- R10: When `inj_en` is 1, the stored bit at position `inj_pos` of lane `inj_lane` at `inj_addr` is inverted on the clock edge. `inj_pos` values 0, 13, 14 and 15 have no effect. A write to the same lane in the same cycle takes precedence, and the injection is then dropped.
- R11: While `rst` is high, `rvld`, `rdata`, `fix` and `bad` are zero. Reset does not clear the stored contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the read registers |
| addr | input | $clog2(DEPTH) | Word address |
| cs_n | input | 1 | Active-low select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| lane_n | input | 2 | Active-low lane enables, bit 0 lower byte |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, one cycle after the request |
| rvld | output | 2 | Per-lane read-data valid |
| fix | output | 2 | Per-lane single error corrected |
| bad | output | 2 | Per-lane uncorrectable pattern seen |
| inj_en | input | 1 | Test: flip one stored bit |
| inj_lane | input | 1 | Test: lane to flip |
| inj_addr | input | $clog2(DEPTH) | Test: word to flip |
| inj_pos | input | 4 | Test: codeword position 1 to 12 |

## Verification
The bench builds the block with DEPTH set to 64. This keeps a six-bit address, so the bench can first write every word, then probe both ends of the address range and run random mixed traffic over the whole array. The bench keeps a model of each lane's written byte and a mask of injected flips. A sweep through all twelve positions in both lanes covers check-bit hits as well as data-bit hits. Paired flips reach the uncorrectable flag.

// File: rtl/blsram_pkg.sv
package blsram_pkg;

    localparam int BYTE_W     = 8;
    localparam int CHK_W      = 4;
    localparam int CW_W       = BYTE_W + CHK_W;
    localparam int LANES      = 2;
    localparam int DATA_W     = LANES * BYTE_W;
    localparam int LANE_SEL_W = $clog2(LANES);

    typedef logic [CW_W-1:0]   cw_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic wr;
        logic rd;
    } lane_op_t;

    typedef struct packed {
        byte_t data;
        logic  fix;
        logic  bad;
    } rd_res_t;

    // codeword position (1-based) holding data bit i
    function automatic int data_pos(input int i);
        if (i < 1)      return 3;
        else if (i < 4) return i + 4;
        else            return i + 5;
    endfunction

    function automatic cw_t ecc_encode(input byte_t d);
        cw_t  cw;
        logic p;
        cw = '0;
        for (int i = 0; i < BYTE_W; i++) cw[data_pos(i)-1] = d[i];
        for (int k = 0; k < CHK_W; k++) begin
            p = 1'b0;
            for (int j = 1; j <= CW_W; j++)
                if (((j >> k) & 1) == 1 && j != (1 << k)) p = p ^ cw[j-1];
            cw[(1 << k)-1] = p;
        end
        return cw;
    endfunction

    function automatic rd_res_t ecc_decode(input cw_t cw);
        logic [CHK_W-1:0] syn;
        cw_t              fixed;
        rd_res_t          r;
        syn = '0;
        for (int j = 1; j <= CW_W; j++)
            if (cw[j-1]) syn = syn ^ CHK_W'(j);
        fixed = cw;
        r.fix = (syn != '0) && (int'(syn) <= CW_W);
        r.bad = (int'(syn) > CW_W);
        if (r.fix) fixed[int'(syn)-1] = ~fixed[int'(syn)-1];
        for (int i = 0; i < BYTE_W; i++) r.data[i] = fixed[data_pos(i)-1];
        return r;
    endfunction

endpackage

// File: rtl/blsram_ctrl.sv
module blsram_ctrl
    import blsram_pkg::*;
(
    input  logic                  cs_n,
    input  logic                  oe_n,
    input  logic                  we_n,
    input  logic [LANES-1:0]      lane_n,
    output lane_op_t [LANES-1:0]  ops
);

    logic sel_wr;
    logic sel_rd;

    always_comb begin
        sel_wr = !cs_n && !we_n;
        sel_rd = !cs_n && we_n && !oe_n;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_op
        always_comb begin
            ops[g].wr = sel_wr && !lane_n[g];
            ops[g].rd = sel_rd && !lane_n[g];
        end
    end

endmodule

// File: rtl/blsram_lane.sv
module blsram_lane
    import blsram_pkg::*;
#(
    parameter  int DEPTH = 256,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  lane_op_t      op,
    input  logic [AW-1:0] addr,
    input  byte_t         wbyte,
    input  logic          inj,
    input  logic [AW-1:0] inj_addr,
    input  logic [3:0]    inj_pos,
    output byte_t         rbyte,
    output logic          rvld,
    output logic          fix,
    output logic          bad
);

    cw_t        mem [DEPTH];
    rd_res_t    res;
    logic       inj_ok;
    logic [3:0] inj_idx;

    always_comb begin
        res     = ecc_decode(mem[addr]);
        inj_ok  = inj && (inj_pos != 4'd0) && (int'(inj_pos) <= CW_W);
        inj_idx = inj_pos - 4'd1;
    end

    // storage: a write wins over a same-cycle injection
    always_ff @(posedge clk) begin
        if (op.wr)
            mem[addr] <= ecc_encode(wbyte);
        else if (inj_ok)
            mem[inj_addr][inj_idx] <= ~mem[inj_addr][inj_idx];
    end

    always_ff @(posedge clk) begin
        if (rst || !op.rd) begin
            rbyte <= '0;
            rvld  <= 1'b0;
            fix   <= 1'b0;
            bad   <= 1'b0;
        end else begin
            rbyte <= res.data;
            rvld  <= 1'b1;
            fix   <= res.fix;
            bad   <= res.bad;
        end
    end

endmodule

// File: rtl/blsram_top.sv
module blsram_top
    import blsram_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [$clog2(DEPTH)-1:0] addr,
    input  logic                     cs_n,
    input  logic                     oe_n,
    input  logic                     we_n,
    input  logic [1:0]               lane_n,
    input  logic [15:0]              wdata,
    output logic [15:0]              rdata,
    output logic [1:0]               rvld,
    output logic [1:0]               fix,
    output logic [1:0]               bad,
    input  logic                     inj_en,
    input  logic                     inj_lane,
    input  logic [$clog2(DEPTH)-1:0] inj_addr,
    input  logic [3:0]               inj_pos
);

    lane_op_t [LANES-1:0] ops;

    blsram_ctrl u_ctrl (
        .cs_n   (cs_n),
        .oe_n   (oe_n),
        .we_n   (we_n),
        .lane_n (lane_n),
        .ops    (ops)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic lane_inj;
        assign lane_inj = inj_en && (inj_lane == LANE_SEL_W'(g));

        blsram_lane #(.DEPTH(DEPTH)) u_lane (
            .clk      (clk),
            .rst      (rst),
            .op       (ops[g]),
            .addr     (addr),
            .wbyte    (wdata[g*BYTE_W +: BYTE_W]),
            .inj      (lane_inj),
            .inj_addr (inj_addr),
            .inj_pos  (inj_pos),
            .rbyte    (rdata[g*BYTE_W +: BYTE_W]),
            .rvld     (rvld[g]),
            .fix      (fix[g]),
            .bad      (bad[g])
        );
    end

endmodule

// File: rtl/blsram_chk.sv
module blsram_chk (
    input logic        clk,
    input logic        rst,
    input logic        cs_n,
    input logic        oe_n,
    input logic        we_n,
    input logic [1:0]  lane_n,
    input logic [15:0] rdata,
    input logic [1:0]  rvld,
    input logic [1:0]  fix,
    input logic [1:0]  bad
);

    // R3
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (rvld == 2'b00));

    // R4
    oe_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && we_n && oe_n) |=> (rvld == 2'b00));

    // R5
    no_lane_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && (&lane_n)) |=> (rvld == 2'b00));

    // R6
    write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !we_n) |=> (rvld == 2'b00));

    for (genvar g = 0; g < 2; g++) begin : g_lane_chk
        // R2
        read_valid_chk: assert property (@(posedge clk) disable iff (rst)
            (!cs_n && we_n && !oe_n && !lane_n[g]) |=> rvld[g]);

        // R2
        valid_cause_chk: assert property (@(posedge clk) disable iff (rst)
            rvld[g] |-> $past(!cs_n && we_n && !oe_n && !lane_n[g]));

        // R7
        idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
            !rvld[g] |-> (rdata[g*8 +: 8] == 8'h00 && !fix[g] && !bad[g]));

        // R9
        flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
            !(fix[g] && bad[g]));
    end

endmodule

bind blsram_top blsram_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .cs_n   (cs_n),
    .oe_n   (oe_n),
    .we_n   (we_n),
    .lane_n (lane_n),
    .rdata  (rdata),
    .rvld   (rvld),
    .fix    (fix),
    .bad    (bad)
);

// File: tb/test_blsram_top.sv
module test_blsram_top;

    localparam int DEPTH = 64;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [1:0]    lane_n = 2'b11;
    logic [15:0]   wdata = '0;
    logic [15:0]   rdata;
    logic [1:0]    rvld, fix, bad;
    logic          inj_en = 1'b0, inj_lane = 1'b0;
    logic [AW-1:0] inj_addr = '0;
    logic [3:0]    inj_pos = '0;

    always #5 clk = ~clk;

    blsram_top #(.DEPTH(DEPTH)) i_blsram_top (
        .clk(clk), .rst(rst), .addr(addr), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
        .lane_n(lane_n), .wdata(wdata), .rdata(rdata), .rvld(rvld), .fix(fix), .bad(bad),
        .inj_en(inj_en), .inj_lane(inj_lane), .inj_addr(inj_addr), .inj_pos(inj_pos)
    );

    typedef struct packed {
        logic [15:0] d;
        logic [1:0]  v;
        logic [1:0]  f;
        logic [1:0]  b;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    logic [7:0]  m_data [2][DEPTH];
    logic [11:0] m_mask [2][DEPTH];

    function automatic int dpos(input int i);
        if (i < 1)      return 3;
        else if (i < 4) return i + 4;
        else            return i + 5;
    endfunction

    // expected read of one lane from its written byte and flip mask (R8, R9)
    function automatic logic [9:0] model_read(input logic [7:0] byt, input logic [11:0] mask);
        int syn = 0;
        logic [11:0] eff = mask;
        logic [7:0]  d = byt;
        logic f, b;
        for (int j = 1; j <= 12; j++) if (mask[j-1]) syn = syn ^ j;
        f = (syn >= 1 && syn <= 12);
        b = (syn > 12);
        if (f) eff[syn-1] = ~eff[syn-1];
        for (int i = 0; i < 8; i++) if (eff[dpos(i)-1]) d[i] = ~d[i];
        return {d, f, b};
    endfunction

    task automatic op(input logic c, input logic o, input logic w, input logic [1:0] ln,
                      input int a, input logic [15:0] wd, input logic ie, input logic il,
                      input int ia, input int ip, input string tag);
        exp_t e;
        logic [9:0] r;
        @(negedge clk);
        cs_n = c; oe_n = o; we_n = w; lane_n = ln; addr = AW'(a); wdata = wd;
        inj_en = ie; inj_lane = il; inj_addr = AW'(ia); inj_pos = 4'(ip);
        e = '0;
        for (int l = 0; l < 2; l++) begin
            if (!c && w && !o && !ln[l]) begin
                r = model_read(m_data[l][a], m_mask[l][a]);
                e.d[l*8 +: 8] = r[9:2];
                e.v[l] = 1'b1;
                e.f[l] = r[1];
                e.b[l] = r[0];
            end
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
        for (int l = 0; l < 2; l++) begin
            if (!c && !w && !ln[l]) begin
                m_data[l][a] = wd[l*8 +: 8];
                m_mask[l][a] = '0;
            end else if (ie && int'(il) == l && ip >= 1 && ip <= 12) begin
                m_mask[l][ia][ip-1] = ~m_mask[l][ia][ip-1];
            end
        end
    endtask

    task automatic wr(input int a, input logic [15:0] wd, input logic [1:0] ln, input string tag);
        op(1'b0, 1'b1, 1'b0, ln, a, wd, 1'b0, 1'b0, 0, 0, tag);
    endtask

    task automatic rd(input int a, input logic [1:0] ln, input string tag);
        op(1'b0, 1'b0, 1'b1, ln, a, 16'h0, 1'b0, 1'b0, 0, 0, tag);
    endtask

    task automatic flip(input logic il, input int ia, input int ip, input string tag);
        op(1'b1, 1'b1, 1'b1, 2'b11, 0, 16'h0, 1'b1, il, ia, ip, tag);
    endtask

    task automatic drain();
        op(1'b1, 1'b1, 1'b1, 2'b11, 0, 16'h0, 1'b0, 1'b0, 0, 0, "idle");
        repeat (3) @(negedge clk);
    endtask

    task automatic reset_check(input string tag);
        n_chk++;
        if (rvld !== 2'b00 || rdata !== 16'h0 || fix !== 2'b00 || bad !== 2'b00) begin
            n_bad++;
            $display("FAIL %s: got d=%h v=%b f=%b b=%b expected all zero", tag, rdata, rvld, fix, bad);
        end
    endtask

    // monitor: pops one expected item per cycle
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_chk++;
                if (rdata !== e.d || rvld !== e.v || fix !== e.f || bad !== e.b) begin
                    n_bad++;
                    $display("FAIL %s: got d=%h v=%b f=%b b=%b expected d=%h v=%b f=%b b=%b",
                             t, rdata, rvld, fix, bad, e.d, e.v, e.f, e.b);
                end
            end
        end
    end

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        reset_check("R11 reset state");
        @(negedge clk);
        rst = 1'b0;

        for (int a = 0; a < DEPTH; a++) wr(a, 16'(a * 16'h0301 + 16'h1111), 2'b00, "R6 write idle");

        wr(0, 16'hA55A, 2'b00, "R6 full write");
        rd(0, 2'b00, "R2 full read");
        wr(1, 16'hBEEF, 2'b00, "R6");
        wr(1, 16'hFF34, 2'b10, "R1 lower only");
        rd(1, 2'b00, "R1 lower merge");
        op(1'b0, 1'b0, 1'b0, 2'b01, 1, 16'h7700, 1'b0, 1'b0, 0, 0, "R1 write with oe low");
        rd(1, 2'b00, "R1 upper merge");
        rd(1, 2'b10, "R7 lower lane only");
        rd(1, 2'b01, "R7 upper lane only");
        op(1'b1, 1'b0, 1'b1, 2'b00, 1, 16'h0, 1'b0, 1'b0, 0, 0, "R3 deselected read");
        op(1'b0, 1'b1, 1'b1, 2'b00, 1, 16'h0, 1'b0, 1'b0, 0, 0, "R4 oe high");
        op(1'b0, 1'b0, 1'b1, 2'b11, 1, 16'h0, 1'b0, 1'b0, 0, 0, "R5 no lane read");
        op(1'b1, 1'b1, 1'b0, 2'b00, 1, 16'hDEAD, 1'b0, 1'b0, 0, 0, "R3 deselected write");
        op(1'b0, 1'b1, 1'b0, 2'b11, 1, 16'hDEAD, 1'b0, 1'b0, 0, 0, "R5 no lane write");
        rd(1, 2'b00, "R3 R5 contents kept");
        wr(DEPTH-1, 16'hC3E1, 2'b00, "R6 top write");
        rd(DEPTH-1, 2'b00, "R2 top address");

        for (int p = 1; p <= 12; p++) begin
            wr(10, 16'h9A5C, 2'b00, "R6");
            flip(1'b0, 10, p, "R10 flip lower");
            rd(10, 2'b00, "R8 lower single");
            wr(11, 16'h3CA7, 2'b00, "R6");
            flip(1'b1, 11, p, "R10 flip upper");
            rd(11, 2'b00, "R8 upper single");
        end

        wr(20, 16'h6E81, 2'b00, "R6");
        flip(1'b0, 20, 5, "R10");
        flip(1'b0, 20, 8, "R10");
        rd(20, 2'b00, "R9 lower double");
        flip(1'b1, 20, 6, "R10");
        flip(1'b1, 20, 9, "R10");
        rd(20, 2'b00, "R9 upper double");

        wr(30, 16'h5511, 2'b00, "R6");
        flip(1'b0, 30, 0, "R10 pos 0");
        flip(1'b1, 30, 13, "R10 pos 13");
        rd(30, 2'b00, "R10 out-of-range positions");
        op(1'b0, 1'b1, 1'b0, 2'b10, 30, 16'h00E4, 1'b1, 1'b0, 30, 3, "R10 write wins");
        rd(30, 2'b00, "R10 write precedence");
        op(1'b0, 1'b1, 1'b0, 2'b10, 30, 16'h0019, 1'b1, 1'b1, 30, 10, "R10 other lane");
        rd(30, 2'b00, "R10 other lane flipped");

        wr(40, 16'h1357, 2'b00, "R6");
        drain();
        rst = 1'b1;
        @(posedge clk);
        #2;
        reset_check("R11 mid-run reset");
        @(negedge clk);
        rst = 1'b0;
        rd(40, 2'b00, "R11 contents survive reset");

        for (int i = 0; i < 300; i++) begin
            int k = $urandom % 4;
            logic [1:0] ln = 2'($urandom);
            int a = $urandom % DEPTH;
            if (k == 0)      wr(a, 16'($urandom), ln, "R1 random write");
            else if (k == 1) rd(a, ln, "R2 random read");
            else if (k == 2) flip(1'($urandom), a, $urandom % 16, "R8 random flip");
            else op(1'($urandom), 1'($urandom), 1'b1, ln, a, 16'($urandom), 1'b0, 1'b0, 0, 0, "R4 random ctl");
        end
        for (int a = 0; a < DEPTH; a++) wr(a, 16'h0F0F, 2'b00, "R6 scrub");
        for (int a = 0; a < DEPTH; a += 9) rd(a, 2'b00, "R2 scrub read");

        drain();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule